// File: doc/BRIEF.md
# Bit-Serial ARX Block Encryption Core (32-bit block, 64-bit key)

This core encrypts one 32-bit block with an add-rotate-XOR cipher that uses 16-bit words. The block is split into an upper word x and a lower word y. Each round computes x' = ((x rotated right by 7) + y mod 2^16) XOR k and then y' = (y rotated left by 2) XOR x'. A full encryption is 22 rounds. The datapath is serial to keep area small. One full-adder and one carry flip-flop produce one bit of x' per clock, least significant bit first. The rotations cost no logic: the core picks which bit index it reads from the held words.

A separate key-expansion block supplies the round keys, one 16-bit word per round. The core pulses `round_req` in every cycle in which it samples `rkey`. The key block must hold the word for the current round on `rkey` during that cycle, and may advance to the next word after the edge. The first request comes in the same cycle as the accepted start. The later requests come in the update cycle of each round that is not the last.

The controller has three states:
- IDLE: waits for `start`. Then IDLE→ADD loads the plaintext and key 0 and clears the carry.
- ADD: lasts 16 cycles, one bit per cycle. ADD→UPDATE follows bit 15.
- UPDATE: lasts one cycle. It writes x' and y' and samples the next key. UPDATE→ADD leads to the next round. UPDATE→IDLE follows round 22 and raises `done`.

Top module: `speck_ser_core`

## Requirements
- R1: After reset `busy`=0, `done`=0, `round_req`=0 and `ct_out`=0.
- R2: `start` high in a cycle where `busy`=0 is accepted at that clock edge. `busy` is 1 from the next cycle on.
- R3: `ct_out` equals 22 rounds of x' = (ror7(x) + y mod 2^16) XOR k, y' = rol2(y) XOR x'. The plaintext gives x = `pt_in[31:16]` and y = `pt_in[15:0]`. The result is output as {x, y} on `ct_out[31:16]` and `ct_out[15:0]`.
- R4: `done` is high in the cycle after the 374th rising edge that follows the accepting edge (22 rounds × 17 cycles). `busy` is 1 for exactly those 374 cycles.
- R5: `done` is a single-cycle pulse and is never high while `busy`=1.
- R6: While `busy`=0 and no start is accepted, `ct_out` holds its value, whatever `pt_in` and `rkey` do.
- R7: `start` while `busy`=1 is ignored. The result, latency and key requests are the same as in an undisturbed run.
- R8: `round_req` is high exactly 22 times per encryption. The first pulse is in the accepting cycle and the later ones come 17 cycles apart. `rkey` is sampled at the edge that ends each `round_req` cycle.
- R9: Addition is modulo 2^16. The final carry is discarded and the carry is cleared before every round, so no carry passes between rounds. This is checked with all-ones operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, accepted only when idle |
| pt_in | input | 32 | Plaintext, x in upper half |
| rkey | input | 16 | Round key word for the current request |
| round_req | output | 1 | Round key sampled this cycle; next word wanted |
| busy | output | 1 | Encryption in progress |
| done | output | 1 | One-cycle completion pulse |
| ct_out | output | 32 | Ciphertext {x, y}, valid from done until next start |

## Verification
`busy` is due one cycle after the accepting edge. `round_req` is combinational in the accepting cycle, then recurs every 17 cycles. `done` and the final `ct_out` are due 374 cycles after the accepting edge. The bench drives inputs on falling edges and samples 1 ns after rising edges. It counts rising edges from the accepting edge and expects `done` at exactly count 374. It also logs the cycle of each key request, so both the spacing and the total count can be checked.

// File: rtl/speck_ser_pkg.sv
package speck_ser_pkg;
    localparam int WORD_W_DEF  = 16;
    localparam int ROUNDS_DEF  = 22;
    localparam int ROT_R_DEF   = 7;
    localparam int ROT_L_DEF   = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADD    = 2'd1,
        ST_UPDATE = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/speck_ser_ctrl.sv
module speck_ser_ctrl
    import speck_ser_pkg::*;
#(
    parameter int W      = WORD_W_DEF,
    parameter int ROUNDS = ROUNDS_DEF,
    localparam int BW    = $clog2(W),
    localparam int RW    = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [BW-1:0] bit_idx,
    output logic          load_en,
    output logic          add_en,
    output logic          upd_en,
    output logic          key_ld,
    output logic          carry_clr,
    output logic          busy,
    output logic          done
);
    ctl_state_t state_q, state_d;
    logic [RW-1:0] round_q;
    logic          last_bit;
    logic          last_round;
    logic          done_q;

    assign last_bit   = (bit_idx == BW'(W - 1));
    assign last_round = (round_q == RW'(ROUNDS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ADD;
            ST_ADD:    if (last_bit) state_d = ST_UPDATE;
            ST_UPDATE: state_d = last_round ? ST_IDLE : ST_ADD;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            round_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    bit_idx <= '0;
                    if (start) round_q <= '0;
                end
                ST_ADD: bit_idx <= bit_idx + 1'b1;
                ST_UPDATE: begin
                    bit_idx <= '0;
                    if (last_round) done_q <= 1'b1;
                    else            round_q <= round_q + 1'b1;
                end
                default: bit_idx <= '0;
            endcase
        end
    end

    always_comb begin
        load_en   = (state_q == ST_IDLE) && start;
        add_en    = (state_q == ST_ADD);
        upd_en    = (state_q == ST_UPDATE);
        key_ld    = load_en || (upd_en && !last_round);
        carry_clr = load_en || upd_en;
        busy      = (state_q != ST_IDLE);
        done      = done_q;
    end
endmodule

// File: rtl/speck_ser_adder.sv
module speck_ser_adder (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic a,
    input  logic b,
    output logic sum
);
    logic carry_q;

    assign sum = a ^ b ^ carry_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   carry_q <= 1'b0;
        else if (clr) carry_q <= 1'b0;
        else if (en)  carry_q <= (a & b) | (a & carry_q) | (b & carry_q);
    end
endmodule

// File: rtl/speck_ser_datapath.sv
module speck_ser_datapath #(
    parameter int W     = 16,
    parameter int ROT_R = 7,
    parameter int ROT_L = 2,
    localparam int BW   = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          add_en,
    input  logic          upd_en,
    input  logic          key_ld,
    input  logic [2*W-1:0] pt_in,
    input  logic [W-1:0]  rkey,
    input  logic [BW-1:0] bit_idx,
    input  logic          sum_in,
    output logic          a_bit,
    output logic          b_bit,
    output logic [2*W-1:0] blk_out
);
    logic [W-1:0]  x_q, y_q, xn_q, k_q;
    logic [BW-1:0] a_idx;
    logic [W-1:0]  y_rot;

    always_comb begin
        a_idx = BW'((32'(bit_idx) + ROT_R) % W);
        a_bit = x_q[a_idx];
        b_bit = y_q[bit_idx];
        y_rot = (y_q << ROT_L) | (y_q >> (W - ROT_L));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q  <= '0;
            y_q  <= '0;
            xn_q <= '0;
            k_q  <= '0;
        end else begin
            if (key_ld) k_q <= rkey;
            if (load_en) begin
                x_q <= pt_in[2*W-1:W];
                y_q <= pt_in[W-1:0];
            end else if (add_en) begin
                xn_q <= {sum_in ^ k_q[bit_idx], xn_q[W-1:1]};
            end else if (upd_en) begin
                x_q <= xn_q;
                y_q <= y_rot ^ xn_q;
            end
        end
    end

    assign blk_out = {x_q, y_q};
endmodule

// File: rtl/speck_ser_core.sv
module speck_ser_core
    import speck_ser_pkg::*;
#(
    parameter int W      = WORD_W_DEF,
    parameter int ROUNDS = ROUNDS_DEF,
    parameter int ROT_R  = ROT_R_DEF,
    parameter int ROT_L  = ROT_L_DEF,
    localparam int BW    = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*W-1:0] pt_in,
    input  logic [W-1:0]   rkey,
    output logic           round_req,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] ct_out
);
    logic [BW-1:0] bit_idx;
    logic load_en, add_en, upd_en, key_ld, carry_clr;
    logic a_bit, b_bit, sum_bit;

    speck_ser_ctrl #(.W(W), .ROUNDS(ROUNDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_idx(bit_idx),
        .load_en(load_en), .add_en(add_en), .upd_en(upd_en),
        .key_ld(key_ld), .carry_clr(carry_clr), .busy(busy), .done(done)
    );

    speck_ser_adder u_add (
        .clk(clk), .rst_n(rst_n), .clr(carry_clr), .en(add_en),
        .a(a_bit), .b(b_bit), .sum(sum_bit)
    );

    speck_ser_datapath #(.W(W), .ROT_R(ROT_R), .ROT_L(ROT_L)) u_dp (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .add_en(add_en),
        .upd_en(upd_en), .key_ld(key_ld), .pt_in(pt_in), .rkey(rkey),
        .bit_idx(bit_idx), .sum_in(sum_bit), .a_bit(a_bit), .b_bit(b_bit),
        .blk_out(ct_out)
    );

    assign round_req = key_ld;
endmodule

// File: rtl/speck_ser_chk.sv
module speck_ser_chk #(
    parameter int W      = 16,
    parameter int ROUNDS = 22,
    localparam int LAT   = ROUNDS * (W + 1),
    localparam int CW    = $clog2(LAT + 2)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           round_req,
    input logic [2*W-1:0] ct_out
);
    logic [CW-1:0] busy_cnt;
    logic [4:0]    gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            gap_cnt  <= '0;
        end else begin
            if (!busy && start) busy_cnt <= '0;
            else if (busy)      busy_cnt <= busy_cnt + 1'b1;
            if (round_req)      gap_cnt <= 5'd1;
            else if (gap_cnt != 5'd31) gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !done);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_cnt == CW'(LAT));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(ct_out));

    // R8
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (round_req && busy) |-> gap_cnt == 5'(W + 1));
endmodule

bind speck_ser_core speck_ser_chk #(.W(W), .ROUNDS(ROUNDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .round_req(round_req), .ct_out(ct_out)
);

// File: tb/speck_ser_core_bench.sv
module speck_ser_core_bench;
    localparam int NR  = 22;
    localparam int LAT = 374;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] pt_in = '0;
    logic [15:0] rkey;
    logic        round_req, busy, done;
    logic [31:0] ct_out;

    int checks = 0;
    int fails  = 0;

    logic [15:0] rk [NR];
    int          kidx;
    logic        kclr = 1'b0;
    int          req_cnt;
    int          cyc;
    int          last_req_cyc;
    int          bad_gap;

    always #5 clk = ~clk;

    speck_ser_core u_speck_ser_core (
        .clk(clk), .rst_n(rst_n), .start(start), .pt_in(pt_in), .rkey(rkey),
        .round_req(round_req), .busy(busy), .done(done), .ct_out(ct_out)
    );

    assign rkey = (kidx < NR) ? rk[kidx] : 16'hDEAD;

    always_ff @(posedge clk) begin
        cyc <= cyc + 1;
        if (kclr) begin
            kidx <= 0; req_cnt <= 0; bad_gap <= 0;
        end else if (round_req) begin
            kidx    <= kidx + 1;
            req_cnt <= req_cnt + 1;
            if (req_cnt > 0 && cyc - last_req_cyc != 17) bad_gap <= bad_gap + 1;
            last_req_cyc <= cyc;
        end
    end

    initial begin cyc = 0; kidx = 0; req_cnt = 0; bad_gap = 0; last_req_cyc = 0; end

    function automatic logic [15:0] ror(input logic [15:0] v, input int s);
        return (v >> s) | (v << (16 - s));
    endfunction
    function automatic logic [15:0] rol(input logic [15:0] v, input int s);
        return (v << s) | (v >> (16 - s));
    endfunction

    task automatic set_keys(input logic [63:0] key);
        logic [15:0] l [NR + 2];
        l[0] = key[31:16]; l[1] = key[47:32]; l[2] = key[63:48];
        rk[0] = key[15:0];
        for (int i = 0; i < NR - 1; i++) begin
            l[i+3]  = (ror(l[i], 7) + rk[i]) ^ 16'(i);
            rk[i+1] = rol(rk[i], 2) ^ l[i+3];
        end
    endtask

    function automatic logic [31:0] ref_enc(input logic [31:0] pt);
        logic [15:0] x, y;
        x = pt[31:16]; y = pt[15:0];
        for (int i = 0; i < NR; i++) begin
            x = (ror(x, 7) + y) ^ rk[i];
            y = rol(y, 2) ^ x;
        end
        return {x, y};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one encryption; optional stray start pulse while busy at cycle stray_at.
    task automatic run_enc(input logic [31:0] pt, input int stray_at,
                           output logic [31:0] ct, output int lat, output logic req0);
        @(negedge clk); kclr = 1'b1;
        @(negedge clk); kclr = 1'b0; start = 1'b1; pt_in = pt;
        #1 req0 = round_req;
        @(posedge clk); #1 start = 1'b0;
        lat = 0;
        while (!done && lat < LAT + 20) begin
            if (lat == stray_at) begin
                @(negedge clk); start = 1'b1; pt_in = ~pt;
                @(negedge clk); start = 1'b0;
                @(posedge clk); #1 lat += 2;
            end else begin
                @(posedge clk); #1 lat++;
            end
        end
        ct = ct_out;
    endtask

    task automatic t_reset();
        #1;
        check("R1 busy", 64'(busy), 0);
        check("R1 done", 64'(done), 0);
        check("R1 round_req", 64'(round_req), 0);
        check("R1 ct_out", 64'(ct_out), 0);
    endtask

    task automatic t_vector(input string tag, input logic [63:0] key, input logic [31:0] pt,
                            input int stray_at);
        logic [31:0] ct; int lat; logic r0;
        set_keys(key);
        run_enc(pt, stray_at, ct, lat, r0);
        check({tag, " R3 ciphertext"}, 64'(ct), 64'(ref_enc(pt)));
        check({tag, " R4 latency"}, 64'(lat), 64'(LAT));
        check({tag, " R8 first request with start"}, 64'(r0), 1);
        check({tag, " R8 request count"}, 64'(req_cnt), 64'(NR));
        check({tag, " R8 request spacing"}, 64'(bad_gap), 0);
    endtask

    task automatic t_known();
        set_keys(64'h1918_1110_0908_0100);
        check("R3 reference model", 64'(ref_enc(32'h6574_694c)), 64'h a868_42f2);
        t_vector("known", 64'h1918_1110_0908_0100, 32'h6574_694c, -1);
        check("R3 known ct", 64'(ct_out), 64'ha868_42f2);
    endtask

    task automatic t_done_and_hold();
        logic [31:0] held;
        t_vector("hold", 64'h0123_4567_89ab_cdef, 32'hcafe_f00d, -1);
        check("R5 done high / busy low", 64'({done, busy}), 64'b10);
        held = ct_out;
        @(posedge clk); #1;
        check("R5 done single pulse", 64'(done), 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); pt_in = 32'h1111_1111 * i; kclr = 1'b1;
        end
        @(negedge clk); kclr = 1'b0;
        @(posedge clk); #1;
        check("R6 ct held while idle", 64'(ct_out), 64'(held));
    endtask

    initial begin : watchdog
        #3_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_known();
        t_vector("R3 zeros", 64'h0, 32'h0, -1);
        t_vector("R9 all-ones carry", 64'hffff_ffff_ffff_ffff, 32'hffff_ffff, -1);
        t_vector("R3 mixed", 64'h5a5a_a5a5_0f0f_f0f0, 32'h8000_0001, -1);
        t_vector("R7 stray start", 64'h1357_9bdf_2468_ace0, 32'h7777_1234, 40);
        t_vector("R7 stray start late", 64'h1357_9bdf_2468_ace0, 32'h0bad_beef, 300);
        t_done_and_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule